// File: doc/BRIEF.md
# Device Configuration Space Register File

This block holds the 256-byte configuration space of one bus device. A host
reaches it with an 8-bit byte offset, an access length of one, two or four
bytes, a write strobe and 32 bits of write data. Reads are combinational and
little-endian. Writes take effect on the next rising clock edge.

Write protection is decided per byte. The header-type byte selects one of two
protection maps: the ordinary endpoint map or the bridge map. A four-byte write
that lands in the base-address window or in the endpoint expansion-ROM window
does not use these maps. It takes a separate path that clears the address bits
below the region size that the parameters give. The ROM register keeps its
enable bit through this path. Reserved bits of the command and status
registers always read as zero.

A one-cycle remap pulse tells the address decoders to re-evaluate after a
command or base-address change. A bridge instance also keeps a secondary bus
number register next to the stored bytes.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, an endpoint instance (IS_BRIDGE=0) holds the vendor ID at offsets 0x00-0x01, the device ID at 0x02-0x03 and SUBSYS_ID at 0x2C-0x2F, each stored little-endian. Every other byte, including the header-type byte at 0x0E, is zero.
- R2: After reset, a bridge instance holds the same IDs plus these bytes: 0x04 = 0x06, 0x06 = 0xA0, 0x0A = 0x04, 0x0B = 0x06, 0x0D = 0x10, 0x0E = 0x81, 0x1E = 0xA0. Its secondary bus number output is 0.
- R3: A read returns the byte at the offset in bits 7:0, the next byte in bits 15:8, and so on (little-endian). Bits above the access length read as zero.
- R4: The read returns 0xFFFFFFFF in three cases: a four-byte read at an offset above 0xFC, a two-byte read at an offset above 0xFE, or a length code other than 1, 2 or 4. One-byte reads are valid at every offset.
- R5: A four-byte write at an offset from 0x10 to 0x27 is a base-address write. It selects region (offset-0x10)/4 and stores the data ANDed with ~(2^BAR_LOG2[region]-1) into the four bytes at the offset. A region with BAR_LOG2 of 32 stores zero.
- R6: A four-byte write at an offset from 0x30 to 0x33 is a ROM write. It is size-masked with BAR_LOG2[6], but bit 0 (the enable bit) passes through unmasked.
- R7: With the endpoint map (header byte bits 6:0 not equal to 1), byte writes are ignored at 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x2C-0x33 and 0x3D. Base-address bytes therefore change only through R5/R6.
- R8: With the bridge map (header byte bits 6:0 equal to 1), byte writes are ignored at 0x00-0x03, 0x08-0x0B, 0x0E, 0x2C-0x2F, 0x38-0x3B and 0x3D. Bytes 0x10-0x27 accept byte writes.
- R9: Bits set in CMD_HI_RSVD (0xF8) are cleared on every write to byte 0x05. Bits set in STAT_LO_RSVD (0x07) are cleared on every write to byte 0x06. Bits set in STAT_HI_RSVD are cleared on every write to byte 0x07.
- R10: remap_o is high for the one cycle after each accepted write that covers byte 0x04 or 0x05, and after each R5/R6 write. It is low after any cycle without such a write.
- R11: A write that is not an R5/R6 write is applied byte by byte. Each byte uses its own protection-map entry. Bytes past offset 0xFF are dropped, and a write with a length code other than 1, 2 or 4 changes nothing.
- R12: On a bridge, a write at offset 0x19 loads the secondary bus number from data bits 7:0. A write of two or more bytes at 0x18 loads it from bits 15:8. Any other write leaves the number unchanged, even one that covers byte 0x19 from a lower offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| off_i | input | 8 | Byte offset of the access |
| len_i | input | 3 | Access length code: 1, 2 or 4 |
| wr_i | input | 1 | Write strobe for this cycle |
| wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| rdata_o | output | 32 | Read data for off_i/len_i |
| remap_o | output | 1 | One-cycle request to re-evaluate decoding |
| sec_bus_o | output | 8 | Secondary bus number (bridge only, else 0) |

## Verification
Base-address writes are driven with all-ones data, which exposes the size mask directly. Arbitrary data is then used to show that high bits pass while low bits clear, and ROM data with bit 0 set and clear tells enable preservation apart from plain masking.

Byte, word and dword writes are aimed at protected bytes, at neighbouring writable bytes, and across protected/writable boundaries, so per-byte enabling is told apart from whole-access rejection. An endpoint and a bridge instance share one stimulus stream, so a single write shows both protection maps side by side.

Reads are placed exactly at the 0xFC/0xFE limits and one byte beyond them. Secondary-bus writes cover the offset-0x19 case, the two-byte-at-0x18 case, the single-byte-at-0x18 case and the covering-from-below case.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam logic [7:0] OFS_CMD_LO  = 8'h04;
    localparam logic [7:0] OFS_CMD_HI  = 8'h05;
    localparam logic [7:0] OFS_STAT_LO = 8'h06;
    localparam logic [7:0] OFS_STAT_HI = 8'h07;
    localparam logic [7:0] OFS_HDR     = 8'h0E;
    localparam logic [7:0] OFS_BUS_LO  = 8'h18;
    localparam logic [7:0] OFS_BUS_SEC = 8'h19;

    typedef enum logic [0:0] {
        MAP_ENDPOINT = 1'b0,
        MAP_BRIDGE   = 1'b1
    } wmap_e;

    function automatic logic len_legal(input logic [2:0] l);
        return (l == 3'd1) || (l == 3'd2) || (l == 3'd4);
    endfunction

    // Bytes that never take a plain byte write, per protection map.
    function automatic logic byte_locked(input logic [7:0] a, input wmap_e m);
        logic common;
        common = (a inside {[8'h00:8'h03], [8'h08:8'h0B], 8'h0E,
                            [8'h2C:8'h2F], 8'h3D});
        if (m == MAP_BRIDGE)
            return common || (a inside {[8'h38:8'h3B]});
        return common || (a inside {[8'h10:8'h27], [8'h30:8'h33]});
    endfunction

    // Address mask for a region of 2^l2 bytes; 32 or more means unimplemented.
    function automatic logic [31:0] size_mask(input logic [5:0] l2);
        if (l2 >= 6'd32)
            return 32'h0;
        return ~((32'h1 << l2) - 32'h1);
    endfunction

endpackage

// File: rtl/cfg_lane_guard.sv
module cfg_lane_guard
    import cfgspace_pkg::*;
#(
    parameter logic [7:0] CMD_HI_RSVD  = 8'hF8,
    parameter logic [7:0] STAT_LO_RSVD = 8'h07,
    parameter logic [7:0] STAT_HI_RSVD = 8'h00
) (
    input  wmap_e       wmap_i,
    input  logic [8:0]  lane_addr_i,
    input  logic        lane_on_i,
    input  logic [7:0]  wbyte_i,
    output logic        we_o,
    output logic [7:0]  wbyte_o
);

    logic in_space;

    always_comb begin
        in_space = !lane_addr_i[8];
        we_o     = lane_on_i && in_space && !byte_locked(lane_addr_i[7:0], wmap_i);
    end

    always_comb begin
        unique case (lane_addr_i[7:0])
            OFS_CMD_HI:  wbyte_o = wbyte_i & ~CMD_HI_RSVD;
            OFS_STAT_LO: wbyte_o = wbyte_i & ~STAT_LO_RSVD;
            OFS_STAT_HI: wbyte_o = wbyte_i & ~STAT_HI_RSVD;
            default:     wbyte_o = wbyte_i;
        endcase
    end

endmodule

// File: rtl/cfg_bar_path.sv
module cfg_bar_path
    import cfgspace_pkg::*;
#(
    parameter int         NUM_REGIONS = 7,
    parameter logic [NUM_REGIONS-1:0][5:0] BAR_LOG2 =
        {6'd16, 6'd32, 6'd32, 6'd32, 6'd32, 6'd12, 6'd4}
) (
    input  logic [7:0]  off_i,
    input  logic [2:0]  len_i,
    input  logic [31:0] wdata_i,
    output logic        hit_o,
    output logic        rom_o,
    output logic [31:0] value_o
);

    localparam int ROM_IDX = NUM_REGIONS - 1;

    logic [31:0] mask_tab [NUM_REGIONS];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_mask
        assign mask_tab[g] = size_mask(BAR_LOG2[g]);
    end

    logic        in_bar;
    logic [31:0] sel_mask;

    always_comb begin
        in_bar = off_i inside {[8'h10:8'h27]};
        rom_o  = off_i inside {[8'h30:8'h33]};
        hit_o  = (len_i == 3'd4) && (in_bar || rom_o);
    end

    always_comb begin
        unique case (off_i[5:2])
            4'h4:    sel_mask = mask_tab[0];
            4'h5:    sel_mask = mask_tab[1];
            4'h6:    sel_mask = mask_tab[2];
            4'h7:    sel_mask = mask_tab[3];
            4'h8:    sel_mask = mask_tab[4];
            4'h9:    sel_mask = mask_tab[5];
            default: sel_mask = mask_tab[ROM_IDX];
        endcase
        if (rom_o)
            value_o = wdata_i & (mask_tab[ROM_IDX] | 32'h1);
        else
            value_o = wdata_i & sel_mask;
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       off_i,
    input  logic [2:0]       len_i,
    input  logic [3:0][7:0]  bytes_i,
    output logic [31:0]      rdata_o
);

    logic ok;

    always_comb begin
        ok = (len_i == 3'd1) ||
             ((len_i == 3'd2) && (off_i <= 8'hFE)) ||
             ((len_i == 3'd4) && (off_i <= 8'hFC));
        if (!ok)
            rdata_o = 32'hFFFF_FFFF;
        else if (len_i == 3'd1)
            rdata_o = {24'h0, bytes_i[0]};
        else if (len_i == 3'd2)
            rdata_o = {16'h0, bytes_i[1], bytes_i[0]};
        else
            rdata_o = {bytes_i[3], bytes_i[2], bytes_i[1], bytes_i[0]};
    end

    AST_RD_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == 3'd1) |-> (rdata_o[31:8] == 24'h0)); // R3

    AST_RD_DWORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((len_i == 3'd4) && (off_i > 8'hFC)) |-> (rdata_o == 32'hFFFF_FFFF)); // R4

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
    import cfgspace_pkg::*;
#(
    parameter bit          IS_BRIDGE    = 1'b0,
    parameter logic [15:0] VENDOR_ID    = 16'hABCD,
    parameter logic [15:0] DEVICE_ID    = 16'h1234,
    parameter logic [31:0] SUBSYS_ID    = 32'h5678_9ABC,
    parameter int          NUM_REGIONS  = 7,
    parameter logic [NUM_REGIONS-1:0][5:0] BAR_LOG2 =
        {6'd16, 6'd32, 6'd32, 6'd32, 6'd32, 6'd12, 6'd4},
    parameter logic [7:0]  CMD_HI_RSVD  = 8'hF8,
    parameter logic [7:0]  STAT_LO_RSVD = 8'h07,
    parameter logic [7:0]  STAT_HI_RSVD = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  off_i,
    input  logic [2:0]  len_i,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        remap_o,
    output logic [7:0]  sec_bus_o
);

    localparam int SPACE_BYTES = 256;
    localparam int LANES       = 4;

    function automatic logic [7:0] rst_byte(input int a);
        if (a == 'h00) return VENDOR_ID[7:0];
        if (a == 'h01) return VENDOR_ID[15:8];
        if (a == 'h02) return DEVICE_ID[7:0];
        if (a == 'h03) return DEVICE_ID[15:8];
        if (a == 'h2C) return SUBSYS_ID[7:0];
        if (a == 'h2D) return SUBSYS_ID[15:8];
        if (a == 'h2E) return SUBSYS_ID[23:16];
        if (a == 'h2F) return SUBSYS_ID[31:24];
        if (IS_BRIDGE) begin
            if (a == 'h04) return 8'h06;
            if (a == 'h06) return 8'hA0;
            if (a == 'h0A) return 8'h04;
            if (a == 'h0B) return 8'h06;
            if (a == 'h0D) return 8'h10;
            if (a == 'h0E) return 8'h81;
            if (a == 'h1E) return 8'hA0;
        end
        return 8'h00;
    endfunction

    logic [7:0]       mem [SPACE_BYTES];
    logic [8:0]       lane_addr [LANES];
    logic [LANES-1:0] lane_on;
    logic [LANES-1:0] lane_we;
    logic [7:0]       lane_wb [LANES];
    logic [3:0][7:0]  rd_bytes;
    wmap_e            wmap;
    logic             wr_ok;
    logic             bar_hit;
    logic             bar_rom;
    logic [31:0]      bar_val;
    logic             touches_cmd;
    logic             remap_q;

    always_comb begin
        wr_ok = wr_i && len_legal(len_i);
        wmap  = (mem[OFS_HDR][6:0] == 7'h01) ? MAP_BRIDGE : MAP_ENDPOINT;
        touches_cmd = ({1'b0, off_i} <= {1'b0, OFS_CMD_HI}) &&
                      (({1'b0, off_i} + {6'b0, len_i}) > {1'b0, OFS_CMD_LO});
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l] = {1'b0, off_i} + 9'(l);
            lane_on[l]   = wr_ok && !bar_hit && (l < int'(len_i));
            rd_bytes[l]  = lane_addr[l][8] ? 8'h00 : mem[lane_addr[l][7:0]];
        end
    end

    cfg_bar_path #(
        .NUM_REGIONS (NUM_REGIONS),
        .BAR_LOG2    (BAR_LOG2)
    ) u_bar (
        .off_i   (off_i),
        .len_i   (len_i),
        .wdata_i (wdata_i),
        .hit_o   (bar_hit),
        .rom_o   (bar_rom),
        .value_o (bar_val)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cfg_lane_guard #(
            .CMD_HI_RSVD  (CMD_HI_RSVD),
            .STAT_LO_RSVD (STAT_LO_RSVD),
            .STAT_HI_RSVD (STAT_HI_RSVD)
        ) u_guard (
            .wmap_i      (wmap),
            .lane_addr_i (lane_addr[g]),
            .lane_on_i   (lane_on[g]),
            .wbyte_i     (wdata_i[8*g +: 8]),
            .we_o        (lane_we[g]),
            .wbyte_o     (lane_wb[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SPACE_BYTES; i++)
                mem[i] <= rst_byte(i);
        end else if (wr_i && bar_hit) begin
            for (int l = 0; l < LANES; l++)
                mem[lane_addr[l][7:0]] <= bar_val[8*l +: 8];
        end else begin
            for (int l = 0; l < LANES; l++)
                if (lane_we[l])
                    mem[lane_addr[l][7:0]] <= lane_wb[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            remap_q <= 1'b0;
        else
            remap_q <= wr_ok && (touches_cmd || bar_hit);
    end

    assign remap_o = remap_q;

    cfg_read_mux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .off_i   (off_i),
        .len_i   (len_i),
        .bytes_i (rd_bytes),
        .rdata_o (rdata_o)
    );

    if (IS_BRIDGE) begin : g_secbus
        logic [7:0] sec_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                sec_q <= 8'h00;
            else if (wr_ok && (off_i == OFS_BUS_SEC))
                sec_q <= wdata_i[7:0];
            else if (wr_ok && (off_i == OFS_BUS_LO) && (len_i != 3'd1))
                sec_q <= wdata_i[15:8];
        end
        assign sec_bus_o = sec_q;
    end else begin : g_nosecbus
        assign sec_bus_o = 8'h00;
    end

    if (!IS_BRIDGE) begin : g_ep_chk
        AST_BAR0_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (({mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10]} &
              ~size_mask(BAR_LOG2[0])) == 32'h0)); // R5
    end

    AST_CMD_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem[OFS_CMD_HI] & CMD_HI_RSVD) == 8'h00)); // R9

    AST_HDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mem[OFS_HDR])); // R7

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable({mem[8'h03], mem[8'h02], mem[8'h01], mem[8'h00]})); // R7

    AST_REMAP_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (len_i == 3'd1) && (off_i == OFS_CMD_HI)) |=> remap_o); // R10

    AST_NO_REMAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> !remap_o); // R10

    AST_SECBUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(sec_bus_o)); // R12

endmodule

// File: tb/cfg_space_regs_tb.sv
module cfg_space_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  off;
        logic [2:0]  len;
        logic [31:0] data;   // write data, or expected read data
        logic        remap;  // expected remap pulse after a write
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 3'd4, 32'h1234ABCD, 1'b0, 4'd1},  // R1 ids
        '{1'b0, 8'h02, 3'd2, 32'h00001234, 1'b0, 4'd3},  // R3 word
        '{1'b0, 8'h01, 3'd1, 32'h000000AB, 1'b0, 4'd3},  // R3 byte
        '{1'b0, 8'h2C, 3'd4, 32'h56789ABC, 1'b0, 4'd1},  // R1 subsystem
        '{1'b0, 8'h0C, 3'd4, 32'h00000000, 1'b0, 4'd1},  // R1 header zero
        '{1'b0, 8'hFC, 3'd4, 32'h00000000, 1'b0, 4'd4},  // R4 last dword
        '{1'b0, 8'hFD, 3'd4, 32'hFFFFFFFF, 1'b0, 4'd4},  // R4 dword past limit
        '{1'b0, 8'hFE, 3'd2, 32'h00000000, 1'b0, 4'd4},  // R4 last word
        '{1'b0, 8'hFF, 3'd2, 32'hFFFFFFFF, 1'b0, 4'd4},  // R4 word past limit
        '{1'b0, 8'hFF, 3'd1, 32'h00000000, 1'b0, 4'd4},  // R4 byte at top
        '{1'b0, 8'h00, 3'd3, 32'hFFFFFFFF, 1'b0, 4'd4},  // R4 bad length
        '{1'b1, 8'h10, 3'd4, 32'hFFFFFFFF, 1'b1, 4'd5},  // R5 size probe
        '{1'b0, 8'h10, 3'd4, 32'hFFFFFFF0, 1'b0, 4'd5},
        '{1'b1, 8'h14, 3'd4, 32'h12345678, 1'b1, 4'd5},  // R5 4K region
        '{1'b0, 8'h14, 3'd4, 32'h12345000, 1'b0, 4'd5},
        '{1'b1, 8'h18, 3'd4, 32'hFFFFFFFF, 1'b1, 4'd5},  // R5 unimplemented
        '{1'b0, 8'h18, 3'd4, 32'h00000000, 1'b0, 4'd5},
        '{1'b1, 8'h30, 3'd4, 32'hFFFFFFFF, 1'b1, 4'd6},  // R6 rom probe
        '{1'b0, 8'h30, 3'd4, 32'hFFFF0001, 1'b0, 4'd6},
        '{1'b1, 8'h30, 3'd4, 32'h12345672, 1'b1, 4'd6},  // R6 enable clear
        '{1'b0, 8'h30, 3'd4, 32'h12340000, 1'b0, 4'd6},
        '{1'b1, 8'h30, 3'd4, 32'h00AB0003, 1'b1, 4'd6},  // R6 enable set
        '{1'b0, 8'h30, 3'd4, 32'h00AB0001, 1'b0, 4'd6},
        '{1'b1, 8'h10, 3'd1, 32'h00000055, 1'b0, 4'd7},  // R7 bar byte locked
        '{1'b0, 8'h10, 3'd4, 32'hFFFFFFF0, 1'b0, 4'd7},
        '{1'b1, 8'h2C, 3'd4, 32'h00000000, 1'b0, 4'd7},  // R7 subsystem locked
        '{1'b0, 8'h2C, 3'd4, 32'h56789ABC, 1'b0, 4'd7},
        '{1'b1, 8'h00, 3'd4, 32'hFFFFFFFF, 1'b0, 4'd7},  // R7 ids locked
        '{1'b0, 8'h00, 3'd4, 32'h1234ABCD, 1'b0, 4'd7},
        '{1'b1, 8'h0E, 3'd1, 32'h000000FF, 1'b0, 4'd7},  // R7 header locked
        '{1'b0, 8'h0E, 3'd1, 32'h00000000, 1'b0, 4'd7},
        '{1'b1, 8'h3C, 3'd2, 32'h00000102, 1'b0, 4'd11}, // R11 split word
        '{1'b0, 8'h3C, 3'd2, 32'h00000002, 1'b0, 4'd11},
        '{1'b1, 8'h0D, 3'd1, 32'h00000020, 1'b0, 4'd11}, // R11 plain byte
        '{1'b0, 8'h0D, 3'd1, 32'h00000020, 1'b0, 4'd11},
        '{1'b1, 8'h04, 3'd2, 32'h0000FFFF, 1'b1, 4'd9},  // R9 command
        '{1'b0, 8'h04, 3'd2, 32'h000007FF, 1'b0, 4'd9},
        '{1'b1, 8'h06, 3'd2, 32'h0000FFFF, 1'b0, 4'd9},  // R9 status, no remap
        '{1'b0, 8'h06, 3'd2, 32'h0000FFF8, 1'b0, 4'd9},
        '{1'b1, 8'h03, 3'd2, 32'h00001122, 1'b1, 4'd10}, // R10 covers 0x04
        '{1'b0, 8'h02, 3'd4, 32'h07111234, 1'b0, 4'd11},
        '{1'b1, 8'hFE, 3'd4, 32'hAABBCCDD, 1'b0, 4'd11}, // R11 past top
        '{1'b0, 8'hFE, 3'd2, 32'h0000CCDD, 1'b0, 4'd11},
        '{1'b0, 8'hFC, 3'd4, 32'hCCDD0000, 1'b0, 4'd11},
        '{1'b1, 8'h40, 3'd4, 32'h11223344, 1'b0, 4'd11}, // R11 dword
        '{1'b0, 8'h41, 3'd2, 32'h00002233, 1'b0, 4'd3},
        '{1'b1, 8'h50, 3'd3, 32'hFFFFFFFF, 1'b0, 4'd11}, // R11 bad length
        '{1'b0, 8'h50, 3'd4, 32'h00000000, 1'b0, 4'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  off = 8'h00;
    logic [2:0]  len = 3'd1;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata_a, rdata_b;
    logic        remap_a, remap_b;
    logic [7:0]  sec_a, sec_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_space_regs #(.IS_BRIDGE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .off_i(off), .len_i(len), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata_a), .remap_o(remap_a), .sec_bus_o(sec_a)
    );

    cfg_space_regs #(.IS_BRIDGE(1'b1)) u_brg (
        .clk(clk), .rst_n(rst_n), .off_i(off), .len_i(len), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata_b), .remap_o(remap_b), .sec_bus_o(sec_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_rd(input logic [7:0] o, input logic [2:0] l);
        @(negedge clk);
        wr  = 1'b0;
        off = o;
        len = l;
        #1;
    endtask

    // Drive a write for one edge; return with the pulse cycle visible.
    task automatic do_wr(input logic [7:0] o, input logic [2:0] l, input logic [31:0] d);
        @(negedge clk);
        off   = o;
        len   = l;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 bridge reset values, before any write
        do_rd(8'h04, 3'd4); check("R2 cmd/status", rdata_b, 32'h00A00006);
        do_rd(8'h08, 3'd4); check("R2 class", rdata_b, 32'h06040000);
        do_rd(8'h0C, 3'd4); check("R2 latency/header", rdata_b, 32'h00811000);
        do_rd(8'h1C, 3'd4); check("R2 secondary status", rdata_b, 32'h00A00000);
        check("R2 secondary bus", {24'h0, sec_b}, 32'h0);
        check("R1 remap idle", {31'h0, remap_a}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) begin
                do_wr(VEC[i].off, VEC[i].len, VEC[i].data);
                check($sformatf("R%0d remap vec %0d", VEC[i].req, i),
                      {31'h0, remap_a}, {31'h0, VEC[i].remap});
            end else begin
                do_rd(VEC[i].off, VEC[i].len);
                check($sformatf("R%0d read vec %0d", VEC[i].req, i),
                      rdata_a, VEC[i].data);
            end
        end

        // R10 pulse lasts one cycle
        do_wr(8'h05, 3'd1, 32'h0);
        check("R10 pulse high", {31'h0, remap_a}, 32'h1);
        @(negedge clk);
        check("R10 pulse ends", {31'h0, remap_a}, 32'h0);

        // R12 secondary bus number on the bridge
        do_wr(8'h19, 3'd1, 32'h00000005);
        check("R12 write at 0x19", {24'h0, sec_b}, 32'h05);
        do_rd(8'h19, 3'd1); check("R12 stored byte", rdata_b, 32'h05);
        do_wr(8'h18, 3'd2, 32'h00000700);
        check("R12 word at 0x18", {24'h0, sec_b}, 32'h07);
        do_wr(8'h18, 3'd1, 32'h00000009);
        check("R12 byte at 0x18 ignored", {24'h0, sec_b}, 32'h07);
        do_rd(8'h18, 3'd1); check("R8 byte 0x18 stored", rdata_b, 32'h09);
        do_wr(8'h17, 3'd4, 32'h00330000);
        check("R12 covering write ignored", {24'h0, sec_b}, 32'h07);
        check("R10 unaligned base write", {31'h0, remap_a}, 32'h1);
        do_rd(8'h19, 3'd1); check("R5 unaligned base byte", rdata_b, 32'h33);
        check("R12 endpoint bus zero", {24'h0, sec_a}, 32'h0);

        // R7 versus R8 on the same stimulus
        do_wr(8'h10, 3'd1, 32'h00000077);
        do_rd(8'h10, 3'd1); check("R8 bridge base byte", rdata_b, 32'h77);
        do_rd(8'h10, 3'd4); check("R7 endpoint base kept", rdata_a, 32'hFFFFFFF0);
        do_wr(8'h38, 3'd4, 32'hFFFFFFFF);
        check("R10 no remap 0x38", {31'h0, remap_a}, 32'h0);
        do_rd(8'h38, 3'd4); check("R8 bridge rom locked", rdata_b, 32'h0);
        check("R7 endpoint 0x38 open", rdata_a, 32'hFFFFFFFF);

        finish_run();
    end

endmodule